// File: doc/BRIEF.md
# Speaker Enable and Timer Gate Control Port

This block is a single byte-wide register that sits on a simple synchronous I/O bus at one fixed port address (0x61 by default). A write sets two control lines: the gate input of channel 2 of an external interval timer, and a speaker data enable. Both lines leave the block straight from flip-flops, so the timer and the audio path see clean, glitch-free levels.

A read returns those two control bits, the present output level of the timer channel, and a refresh indication. This indication is not tied to any clock. It is a flag that inverts on every decoded read. Polling software therefore sees bit 4 change between consecutive reads. Read data is registered. It appears on the cycle after the read strobe, and it is zero in every other cycle, so several such ports can be OR-combined onto one return bus.

Top module: `spk_timer_port`

## Requirements
- R1: A decoded write sets `spk_enable` to bit 1 of the write byte from the next clock edge on.
- R2: A decoded write sets `timer_gate` to bit 0 of the write byte from the next clock edge on.
- R3: Read data carries the gate state in bit 0 and the speaker enable in bit 1.
- R4: Read data carries, in bit 5, the level that `timer_out` had in the cycle of the read strobe.
- R5: A refresh flag inverts on every decoded read, and bit 4 of that read holds the inverted value. The first read after reset therefore returns 1 in bit 4.
- R6: Read data bits 2, 3, 6 and 7 are always 0.
- R7: Synchronous active-high reset clears the gate, the speaker enable, the refresh flag and the read data.
- R8: Only address PORT_ADDR is decoded. Strobes at any other address change neither output nor the refresh flag, and they leave `bus_rdata` at 0.
- R9: Read data is valid exactly one cycle after a decoded read strobe. In every other cycle `bus_rdata` is 0.
- R10: When a read and a write strike the port in the same cycle, the read returns the state from before the write, the write still takes effect, and the refresh flag still inverts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | I/O address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data, 0 when not returning a read |
| timer_out | input | 1 | Output level of timer channel 2 |
| timer_gate | output | 1 | Gate of timer channel 2 |
| spk_enable | output | 1 | Speaker data enable |

## Verification
The bench builds the block with ADDR_W = 10 and PORT_ADDR = 0x61. This narrow address space lets it strobe every one of the 1024 addresses and confirm that only one of them decodes. It also writes all 256 byte values to the port, each with a read and with alternating timer levels. This covers every gate/enable combination, both refresh phases, and the reserved bits under all data patterns. Combined read-plus-write strobes and idle cycles after reads cover the ordering rule and the one-cycle validity of the read data.

// File: rtl/spk_port_pkg.sv
package spk_port_pkg;
  // Bit positions within the returned byte; software depends on these.
  localparam int GATE_BIT    = 0;
  localparam int EN_BIT      = 1;
  localparam int REFRESH_BIT = 4;
  localparam int TOUT_BIT    = 5;
  localparam int MIN_DATA_W  = TOUT_BIT + 1;

  typedef struct packed {
    logic refresh;
    logic enable;
    logic gate;
  } spk_state_t;
endpackage

// File: rtl/spk_port_decode.sv
module spk_port_decode #(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] PORT_ADDR = 16'h0061
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              wr_hit,
  output logic              rd_hit
);
  localparam logic [ADDR_W-1:0] MATCH = PORT_ADDR[ADDR_W-1:0];

  logic sel;
  always_comb begin
    sel    = (addr == MATCH);
    wr_hit = sel && wr;
    rd_hit = sel && rd;
  end
endmodule

// File: rtl/spk_port_ctrl.sv
module spk_port_ctrl
  import spk_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_hit,
  input  logic       rd_hit,
  input  logic       wr_gate,
  input  logic       wr_en,
  output spk_state_t state
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= '0;
    end else begin
      if (wr_hit) begin
        state.gate   <= wr_gate;
        state.enable <= wr_en;
      end
      if (rd_hit) state.refresh <= ~state.refresh;
    end
  end

  // R1
  a_r1_enable_follows_write: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> state.enable == $past(wr_en));
  // R2
  a_r2_gate_follows_write: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> state.gate == $past(wr_gate));
  // R5
  a_r5_refresh_inverts: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> state.refresh != $past(state.refresh));
  // R8
  a_r8_idle_keeps_state: assert property (@(posedge clk) disable iff (rst)
    !(wr_hit || rd_hit) |=> $stable(state));
endmodule

// File: rtl/spk_port_rdmux.sv
module spk_port_rdmux
  import spk_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_hit,
  input  spk_state_t        state,
  input  logic              timer_out,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] packed_byte;

  // Assemble the return value from pre-update state; refresh shows its next value.
  always_comb begin
    packed_byte              = '0;
    packed_byte[GATE_BIT]    = state.gate;
    packed_byte[EN_BIT]      = state.enable;
    packed_byte[REFRESH_BIT] = ~state.refresh;
    packed_byte[TOUT_BIT]    = timer_out;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_hit) rdata <= packed_byte;
    else             rdata <= '0;
  end

  // R6
  always @(posedge clk) begin
    a_r6_reserved_zero: assert (rst || (rdata[3:2] == 2'b00 && rdata[DATA_W-1:TOUT_BIT+1] == '0));
  end
  // R9
  a_r9_zero_without_read: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> rdata == '0);
  // R4
  a_r4_timer_level: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> rdata[TOUT_BIT] == $past(timer_out));
endmodule

// File: rtl/spk_timer_port.sv
module spk_timer_port
  import spk_port_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] PORT_ADDR = 16'h0061
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              timer_out,
  output logic              timer_gate,
  output logic              spk_enable
);
  logic       wr_hit, rd_hit;
  spk_state_t state;
  logic       unused_wbits;

  assign unused_wbits = ^bus_wdata[DATA_W-1:EN_BIT+1];

  spk_port_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  spk_port_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_hit(wr_hit), .rd_hit(rd_hit),
    .wr_gate(bus_wdata[GATE_BIT]), .wr_en(bus_wdata[EN_BIT]), .state(state)
  );

  spk_port_rdmux #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_hit(rd_hit), .state(state),
    .timer_out(timer_out), .rdata(bus_rdata)
  );

  assign timer_gate = state.gate;
  assign spk_enable = state.enable;

  // R7
  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> (!timer_gate && !spk_enable && bus_rdata == '0));
  // R10
  a_r10_read_sees_old: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && rd_hit) |=> bus_rdata[GATE_BIT] == $past(timer_gate) && bus_rdata[EN_BIT] == $past(spk_enable));
endmodule

// File: tb/tb_spk_timer_port.sv
module tb_spk_timer_port;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 10;
  localparam int DATA_W     = 8;
  localparam logic [15:0] PORT = 16'h0061;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, timer_out = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic timer_gate, spk_enable;

  int n_checks = 0, n_fail = 0;
  logic m_gate = 0, m_en = 0, m_ref = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spk_timer_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(PORT)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timer_out(timer_out),
    .timer_gate(timer_gate), .spk_enable(spk_enable)
  );

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // One bus cycle; checks the outcome right after the capturing edge.
  task automatic access(input logic [ADDR_W-1:0] a, input logic wr, input logic rd,
                        input logic [7:0] wd, input logic tout, input string tag);
    logic hit;
    logic [7:0] exp_rd;
    @(negedge clk);
    bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = wd; timer_out = tout;
    hit = (a == PORT[ADDR_W-1:0]);
    exp_rd = 8'h00;
    if (hit && rd) begin
      m_ref = ~m_ref;
      exp_rd = {2'b00, tout, m_ref, 2'b00, m_en, m_gate};
    end
    if (hit && wr) begin
      m_gate = wd[0];
      m_en   = wd[1];
    end
    @(posedge clk); #1;
    check({tag, " rdata"}, bus_rdata, exp_rd);
    check({tag, " gate R2"}, timer_gate, m_gate);
    check({tag, " enable R1"}, spk_enable, m_en);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset rdata", bus_rdata, 0);
    check("R7 reset gate", timer_gate, 0);
    check("R7 reset enable", spk_enable, 0);
    @(negedge clk); rst = 0;

    // First read after reset: refresh bit 4 reads 1 (R5).
    access(PORT[ADDR_W-1:0], 0, 1, 8'h00, 0, "R5 first read");
    access('0, 0, 0, 8'h00, 0, "R9 idle after read");

    // All write values, each followed by a read (R1 R2 R3 R4 R5 R6).
    for (int v = 0; v < 256; v++) begin
      access(PORT[ADDR_W-1:0], 1, 0, v[7:0], 0, "R1/R2 write");
      access(PORT[ADDR_W-1:0], 0, 1, 8'h00, v[0], "R3/R4/R5/R6 read");
    end

    // Combined read and write returns old state (R10).
    access(PORT[ADDR_W-1:0], 1, 0, 8'h03, 1, "R10 setup");
    access(PORT[ADDR_W-1:0], 1, 1, 8'h00, 1, "R10 rd+wr");
    access(PORT[ADDR_W-1:0], 1, 1, 8'h02, 0, "R10 rd+wr second");
    access(PORT[ADDR_W-1:0], 0, 1, 8'h00, 0, "R10 readback");

    // Every other address is ignored (R8).
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      if (a != PORT) begin
        access(a[ADDR_W-1:0], 1, 1, {6'h0, ~m_en, ~m_gate}, 1, "R8 foreign addr");
      end
    end
    access(PORT[ADDR_W-1:0], 0, 1, 8'h00, 1, "R8 refresh unchanged");
    access(PORT[ADDR_W-1:0], 0, 0, 8'h00, 1, "R9 no strobe");

    // Reset mid-run clears state (R7).
    @(negedge clk); rst = 1;
    @(posedge clk); #1;
    check("R7 rerst gate", timer_gate, 0);
    check("R7 rerst enable", spk_enable, 0);
    @(negedge clk); rst = 0;
    m_gate = 0; m_en = 0; m_ref = 0;
    access(PORT[ADDR_W-1:0], 0, 1, 8'h00, 0, "R7 R5 refresh after reset");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule